// File: doc/BRIEF.md
# LPC target cycle responder

This block sits on the target side of a Low Pin Count bus and answers I/O and DMA cycles started by the host. It watches the four-bit LAD nibble stream framed by the active-low frame strobe. It decodes the cycle type, address or DMA channel and size, and any host data. After the host turnaround it takes the bus and drives SYNC nibbles. It then returns read data or acknowledges write data, and hands the bus back with a two-clock turnaround. The LAD pins are brought out as separate input, output and output-enable signals, so the pad tri-state sits outside the block.

Behind the bus sits a simple local port. A one-cycle read or write strobe carries the address (or DMA channel and byte index) and the write data. The back-end answers with a ready level, an error level and read data. While ready is low, the block stretches the cycle with long-wait SYNCs. After a bounded number of wait nibbles it ends the cycle on its own with an error SYNC. An error on any byte of a DMA transfer ends the whole transfer. I/O addresses outside a configurable base/size window get no response at all.

Top module: `lpc_target`

## Requirements
- R1: A cycle starts only when LAD is 0000 on the last clock that the frame strobe is low. On the next clock the type nibble is decoded: bits 3:2 = 00 is I/O, bits 3:2 = 10 is DMA, and bit 1 = 1 means the host sends data (write), 0 means the target returns data (read). Any other type is ignored and LAD stays undriven.
- R2: An I/O read (type 0000, then four address nibbles, most significant first, then two host turnaround clocks) is answered with three 0110 nibbles, one 0000 nibble, the data low nibble, the data high nibble, one 1111 nibble, and then LAD is released.
- R3: An I/O write (type 0010, four address nibbles, data low then high nibble, two turnaround clocks) is answered with two 0110 nibbles, one 0000, one 1111, and then release. loc_wr pulses for one clock in the first SYNC clock, with loc_addr and loc_wdata valid. loc_rd behaves the same way on reads. The two strobes are never high together.
- R4: A DMA read (type 1000, channel nibble with channel in bits 2:0, size nibble with bits 1:0 = 00/01/11 for 1/2/4 bytes) answers each byte with three 0101 nibbles, 0000 and two data nibbles (low first). A single 1111 and a release follow the last byte. loc_rd pulses once per byte with loc_dma high, the channel on loc_chan and the byte index in loc_addr[1:0].
- R5: A DMA write (type 1010) takes, for each byte, two data nibbles and two turnaround clocks, then answers with four 0101 nibbles, 0000, 1111 and a release clock, before the next byte. loc_wr pulses once per byte.
- R6: When loc_ready is low after the fixed wait nibbles, 0110 nibbles repeat until loc_ready is high. The cycle then continues with 0000.
- R7: If loc_ready stays low, the block emits exactly TIMEOUT_WAITS wait nibbles (330 by default, counting the fixed ones) and then the error nibble 1010.
- R8: loc_err high when the back-end is ready replaces 0000 with 1010. On a read, the two data nibbles still follow.
- R9: An error SYNC on any DMA byte ends the transfer after that byte. No further bytes are strobed or signalled.
- R10: An I/O address outside [BASE_ADDR, BASE_ADDR+WIN_SIZE) gets no response: LAD stays undriven and no local strobe fires.
- R11: The frame strobe low in any state aborts the current cycle. LAD is released from the next clock on.
- R12: While rst_n is low, LAD is undriven, ldrq_n is high and the frame strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low bus reset, asynchronous assert |
| lframe_n | input | 1 | Active-low cycle frame from host |
| lad_i | input | 4 | LAD nibble as seen at the pins |
| lad_o | output | 4 | LAD nibble driven by the target |
| lad_oe | output | 1 | Output enable for lad_o |
| ldrq_n | output | 1 | DMA request line, held inactive high |
| loc_rd | output | 1 | One-clock local read strobe |
| loc_wr | output | 1 | One-clock local write strobe |
| loc_dma | output | 1 | Current access belongs to a DMA cycle |
| loc_chan | output | 3 | DMA channel of the current access |
| loc_addr | output | 16 | I/O address, or DMA byte index in bits 1:0 |
| loc_wdata | output | 8 | Write data for the local back-end |
| loc_rdata | input | 8 | Read data from the local back-end |
| loc_ready | input | 1 | Back-end has finished the access |
| loc_err | input | 1 | Back-end reports an error, valid with loc_ready |

## Verification
The checker watches, on every clock: quiet pins during reset, release of LAD on the clock after any frame-low clock, single-clock mutually exclusive local strobes, and that no I/O strobe ever fires outside the address window. It also counts any unbroken run of long-wait nibbles and checks that it never exceeds the timeout. The exact nibble order for each cycle type, the per-type wait counts and the read data values can only be shown by the bench's scenarios. The same holds for the ready stretch, the timeout and error endings, the early end of an erroring DMA transfer, and the START-on-last-low-clock rule.

// File: rtl/lpc_target.sv
module lpc_target #(
  parameter logic [15:0] BASE_ADDR     = 16'h0300,
  parameter int unsigned WIN_SIZE      = 16,
  parameter int unsigned IO_RD_WAITS   = 3,
  parameter int unsigned IO_WR_WAITS   = 2,
  parameter int unsigned DMA_RD_WAITS  = 3,
  parameter int unsigned DMA_WR_WAITS  = 4,
  parameter int unsigned TIMEOUT_WAITS = 330
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lframe_n,
  input  logic [3:0]  lad_i,
  output logic [3:0]  lad_o,
  output logic        lad_oe,
  output logic        ldrq_n,
  output logic        loc_rd,
  output logic        loc_wr,
  output logic        loc_dma,
  output logic [2:0]  loc_chan,
  output logic [15:0] loc_addr,
  output logic [7:0]  loc_wdata,
  input  logic [7:0]  loc_rdata,
  input  logic        loc_ready,
  input  logic        loc_err
);

  localparam int          WCNT_W   = $clog2(TIMEOUT_WAITS + 1);
  localparam logic [16:0] WIN_LO   = {1'b0, BASE_ADDR};
  localparam logic [16:0] WIN_HI   = WIN_LO + 17'(WIN_SIZE);
  localparam logic [3:0]  SY_READY = 4'b0000;
  localparam logic [3:0]  SY_SHORT = 4'b0101;
  localparam logic [3:0]  SY_LONG  = 4'b0110;
  localparam logic [3:0]  SY_ERR   = 4'b1010;
  localparam logic [3:0]  NIB_TURN = 4'b1111;

  typedef enum logic [3:0] {
    ST_IDLE, ST_TYPE, ST_ADDR, ST_CHAN, ST_SIZE,
    ST_HDATA, ST_HTAR, ST_SYNC, ST_RDATA, ST_PTAR
  } st_t;

  st_t               st;
  logic [1:0]        nib;
  logic              is_dma, is_wr, err;
  logic [15:0]       addr;
  logic [2:0]        chan;
  logic [1:0]        blast, bidx;
  logic [7:0]        wdata, rdata;
  logic [WCNT_W-1:0] wcnt;

  logic [15:0]       addr_next;
  logic              hit, waiting, timed_out, sync_done, sync_err, more;
  logic [WCNT_W-1:0] nwait;
  logic [3:0]        sync_nib;

  assign addr_next = {addr[11:0], lad_i};
  assign hit       = ({1'b0, addr_next} >= WIN_LO) && ({1'b0, addr_next} < WIN_HI);
  assign nwait     = is_dma ? (is_wr ? WCNT_W'(DMA_WR_WAITS) : WCNT_W'(DMA_RD_WAITS))
                            : (is_wr ? WCNT_W'(IO_WR_WAITS)  : WCNT_W'(IO_RD_WAITS));
  assign waiting   = wcnt < nwait;
  assign timed_out = wcnt >= WCNT_W'(TIMEOUT_WAITS);
  assign sync_done = !waiting && (loc_ready || timed_out);
  assign sync_err  = loc_ready ? loc_err : 1'b1;
  assign more      = is_dma && !err && (bidx != blast);

  always_comb begin
    if (waiting)        sync_nib = is_dma ? SY_SHORT : SY_LONG;
    else if (loc_ready) sync_nib = loc_err ? SY_ERR : SY_READY;
    else if (timed_out) sync_nib = SY_ERR;
    else                sync_nib = SY_LONG;
  end

  always_comb begin
    case (st)
      ST_SYNC:  lad_o = sync_nib;
      ST_RDATA: lad_o = nib[0] ? rdata[7:4] : rdata[3:0];
      ST_PTAR:  lad_o = NIB_TURN;
      default:  lad_o = 4'b0000;
    endcase
  end

  assign lad_oe    = (st == ST_SYNC) || (st == ST_RDATA) || (st == ST_PTAR && nib == 2'd0);
  assign ldrq_n    = 1'b1;
  assign loc_rd    = (st == ST_SYNC) && (wcnt == '0) && !is_wr;
  assign loc_wr    = (st == ST_SYNC) && (wcnt == '0) && is_wr;
  assign loc_dma   = is_dma;
  assign loc_chan  = chan;
  assign loc_addr  = is_dma ? {14'b0, bidx} : addr;
  assign loc_wdata = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      nib    <= '0;
      is_dma <= 1'b0;
      is_wr  <= 1'b0;
      err    <= 1'b0;
      addr   <= '0;
      chan   <= '0;
      blast  <= '0;
      bidx   <= '0;
      wdata  <= '0;
      rdata  <= '0;
      wcnt   <= '0;
    end else if (!lframe_n) begin
      st  <= (lad_i == 4'b0000) ? ST_TYPE : ST_IDLE;
      nib <= '0;
    end else begin
      case (st)
        ST_TYPE: begin
          is_dma <= lad_i[3];
          is_wr  <= lad_i[1];
          err    <= 1'b0;
          bidx   <= '0;
          blast  <= '0;
          nib    <= '0;
          if (!lad_i[2]) st <= lad_i[3] ? ST_CHAN : ST_ADDR;
          else           st <= ST_IDLE;
        end
        ST_ADDR: begin
          addr <= addr_next;
          nib  <= nib + 2'd1;
          if (nib == 2'd3) begin
            if (!hit)       st <= ST_IDLE;
            else if (is_wr) st <= ST_HDATA;
            else            st <= ST_HTAR;
          end
        end
        ST_CHAN: begin
          chan <= lad_i[2:0];
          st   <= ST_SIZE;
        end
        ST_SIZE: begin
          nib   <= '0;
          blast <= lad_i[1:0];
          if (lad_i[1:0] == 2'b10) st <= ST_IDLE;
          else                     st <= is_wr ? ST_HDATA : ST_HTAR;
        end
        ST_HDATA: begin
          if (nib == 2'd0) begin
            wdata[3:0] <= lad_i;
            nib        <= 2'd1;
          end else begin
            wdata[7:4] <= lad_i;
            nib        <= '0;
            st         <= ST_HTAR;
          end
        end
        ST_HTAR: begin
          if (nib == 2'd0) nib <= 2'd1;
          else begin
            nib  <= '0;
            wcnt <= '0;
            st   <= ST_SYNC;
          end
        end
        ST_SYNC: begin
          if (sync_done) begin
            err   <= sync_err;
            rdata <= loc_rdata;
            nib   <= '0;
            st    <= is_wr ? ST_PTAR : ST_RDATA;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_RDATA: begin
          if (nib == 2'd0) nib <= 2'd1;
          else begin
            nib <= '0;
            if (more) begin
              bidx <= bidx + 2'd1;
              wcnt <= '0;
              st   <= ST_SYNC;
            end else begin
              st <= ST_PTAR;
            end
          end
        end
        ST_PTAR: begin
          if (nib == 2'd0) nib <= 2'd1;
          else begin
            nib <= '0;
            if (more && is_wr) begin
              bidx <= bidx + 2'd1;
              st   <= ST_HDATA;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lpc_target_chk.sv
module lpc_target_chk #(
  parameter logic [15:0] BASE_ADDR     = 16'h0300,
  parameter int unsigned WIN_SIZE      = 16,
  parameter int unsigned TIMEOUT_WAITS = 330
) (
  input logic        clk,
  input logic        rst_n,
  input logic        lframe_n,
  input logic [3:0]  lad_o,
  input logic        lad_oe,
  input logic        loc_rd,
  input logic        loc_wr,
  input logic        loc_dma,
  input logic [15:0] loc_addr
);

  localparam logic [16:0] LO = {1'b0, BASE_ADDR};
  localparam logic [16:0] HI = LO + 17'(WIN_SIZE);

  logic [15:0] long_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           long_run <= '0;
    else if (lad_oe && lad_o == 4'b0110)  long_run <= long_run + 16'd1;
    else                                  long_run <= '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !lad_oe); // R12
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) !lframe_n |=> !lad_oe); // R11
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({loc_rd, loc_wr})); // R3
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (loc_rd || loc_wr) |=> !(loc_rd || loc_wr)); // R3
  AST_WINDOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n) ((loc_rd || loc_wr) && !loc_dma) |-> (({1'b0, loc_addr} >= LO) && ({1'b0, loc_addr} < HI))); // R10
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) long_run <= 16'(TIMEOUT_WAITS)); // R7

endmodule

bind lpc_target lpc_target_chk #(
  .BASE_ADDR(BASE_ADDR), .WIN_SIZE(WIN_SIZE), .TIMEOUT_WAITS(TIMEOUT_WAITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_o(lad_o), .lad_oe(lad_oe),
  .loc_rd(loc_rd), .loc_wr(loc_wr), .loc_dma(loc_dma), .loc_addr(loc_addr)
);

// File: tb/lpc_target_bench.sv
module lpc_target_bench;

  localparam logic [15:0] BASE = 16'h0300;
  localparam int          WSIZE = 16;
  localparam int          TO = 330;
  localparam int          NVEC = 9;
  localparam logic [27:0] VEC [NVEC] = '{
    {4'h0, 16'h0300, 8'h5A},
    {4'h2, 16'h030F, 8'hC3},
    {4'h0, 16'h030F, 8'hF0},
    {4'h2, 16'h0300, 8'h0F},
    {4'h0, 16'h02FF, 8'h11},
    {4'h2, 16'h0310, 8'h22},
    {4'h4, 16'h0305, 8'h33},
    {4'h0, 16'h0307, 8'h96},
    {4'hC, 16'h0305, 8'h44}
  };

  logic clk = 1'b0, rst_n = 1'b0, lframe_n = 1'b1;
  logic [3:0] lad_i = 4'hF;
  logic [3:0] lad_o;
  logic lad_oe, ldrq_n, loc_rd, loc_wr, loc_dma;
  logic [2:0] loc_chan;
  logic [15:0] loc_addr;
  logic [7:0] loc_wdata;
  logic [7:0] loc_rdata = 8'h00;
  logic loc_ready = 1'b1, loc_err = 1'b0;

  logic p_ready = 1'b1, p_err = 1'b0;
  logic [7:0] p_rdata = 8'h00;
  logic s_oe, s_dma;
  logic [3:0] s_o;
  logic [2:0] s_chan;
  logic [15:0] s_addr;
  logic [7:0] s_wd;
  int n_chk = 0, n_bad = 0, n_rd = 0, n_wr = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lpc_target #(.BASE_ADDR(BASE), .WIN_SIZE(WSIZE), .TIMEOUT_WAITS(TO)) u_lpc_target (
    .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_i(lad_i), .lad_o(lad_o),
    .lad_oe(lad_oe), .ldrq_n(ldrq_n), .loc_rd(loc_rd), .loc_wr(loc_wr),
    .loc_dma(loc_dma), .loc_chan(loc_chan), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata), .loc_ready(loc_ready), .loc_err(loc_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic fr, input logic [3:0] nib);
    @(negedge clk);
    lframe_n = fr; lad_i = nib;
    loc_ready = p_ready; loc_err = p_err; loc_rdata = p_rdata;
    #1;
    s_oe = lad_oe; s_o = lad_o;
    if (loc_rd) begin n_rd++; s_dma = loc_dma; s_chan = loc_chan; s_addr = loc_addr; end
    if (loc_wr) begin n_wr++; s_dma = loc_dma; s_chan = loc_chan; s_addr = loc_addr; s_wd = loc_wdata; end
  endtask

  task automatic exp_nib(input logic [3:0] v, input string req);
    tick(1'b1, 4'hF);
    chk(s_oe && s_o == v, req, {s_oe, s_o}, {1'b1, v});
  endtask

  task automatic exp_off(input string req);
    tick(1'b1, 4'hF);
    chk(!s_oe, req, s_oe, 0);
  endtask

  task automatic io_head(input logic [3:0] ct, input logic [15:0] a, input logic [7:0] d);
    tick(1'b0, 4'h0);
    tick(1'b1, ct);
    for (int i = 3; i >= 0; i--) tick(1'b1, a[i*4 +: 4]);
    if (ct[1]) begin tick(1'b1, d[3:0]); tick(1'b1, d[7:4]); end
    tick(1'b1, 4'hF); tick(1'b1, 4'hF);
  endtask

  task automatic io_cycle(input logic [3:0] ct, input logic [15:0] a, input logic [7:0] d);
    bit wr, hit;
    int r0, w0;
    string tg;
    wr = ct[1];
    hit = (ct[3:2] == 2'b00) && (int'(a) >= int'(BASE)) && (int'(a) < int'(BASE) + WSIZE);
    tg = wr ? "R3" : "R2";
    r0 = n_rd; w0 = n_wr;
    p_rdata = d; p_ready = 1'b1; p_err = 1'b0;
    io_head(ct, a, d);
    if (hit) begin
      repeat (wr ? 2 : 3) exp_nib(4'b0110, tg);
      exp_nib(4'b0000, tg);
      if (!wr) begin exp_nib(d[3:0], "R2"); exp_nib(d[7:4], "R2"); end
      exp_nib(4'hF, tg);
      exp_off(tg);
      chk(n_rd - r0 == (wr ? 0 : 1), tg, n_rd - r0, wr ? 0 : 1);
      chk(n_wr - w0 == (wr ? 1 : 0), tg, n_wr - w0, wr ? 1 : 0);
      chk(s_addr == a && !s_dma, tg, s_addr, a);
      if (wr) chk(s_wd == d, "R3", s_wd, d);
    end else begin
      repeat (8) exp_off(ct[3:2] != 2'b00 ? "R1" : "R10");
      chk(n_rd == r0 && n_wr == w0, ct[3:2] != 2'b00 ? "R1" : "R10", n_rd + n_wr, r0 + w0);
    end
    tick(1'b1, 4'hF); tick(1'b1, 4'hF);
  endtask

  task automatic dma_read(input logic [1:0] sz, input int nb, input int errb);
    int r0, done;
    r0 = n_rd; done = 0;
    tick(1'b0, 4'h0); tick(1'b1, 4'h8); tick(1'b1, 4'h5); tick(1'b1, {2'b00, sz});
    tick(1'b1, 4'hF); tick(1'b1, 4'hF);
    for (int b = 0; b < nb; b++) begin
      p_err = (b == errb);
      p_rdata = 8'h3C + 8'(b * 17);
      repeat (3) exp_nib(4'b0101, "R4");
      exp_nib((b == errb) ? 4'b1010 : 4'b0000, (b == errb) ? "R8" : "R4");
      chk(s_addr[1:0] == 2'(b) && s_dma && s_chan == 3'd5, "R4", {s_chan, s_addr[1:0]}, {3'd5, 2'(b)});
      exp_nib(p_rdata[3:0], "R4");
      exp_nib(p_rdata[7:4], "R4");
      done++;
      if (b == errb) break;
    end
    p_err = 1'b0;
    exp_nib(4'hF, "R4");
    exp_off("R9");
    exp_off("R9");
    chk(n_rd - r0 == done, "R9", n_rd - r0, done);
  endtask

  task automatic dma_write(input logic [1:0] sz, input int nb);
    int w0;
    logic [7:0] d;
    w0 = n_wr;
    tick(1'b0, 4'h0); tick(1'b1, 4'hA); tick(1'b1, 4'h1); tick(1'b1, {2'b00, sz});
    for (int b = 0; b < nb; b++) begin
      d = 8'h5C ^ 8'(b * 33);
      tick(1'b1, d[3:0]); tick(1'b1, d[7:4]);
      tick(1'b1, 4'hF); tick(1'b1, 4'hF);
      repeat (4) exp_nib(4'b0101, "R5");
      exp_nib(4'b0000, "R5");
      chk(s_wd == d && s_addr[1:0] == 2'(b) && s_dma && s_chan == 3'd1, "R5", s_wd, d);
      exp_nib(4'hF, "R5");
      exp_off("R5");
    end
    exp_off("R5");
    exp_off("R5");
    chk(n_wr - w0 == nb, "R5", n_wr - w0, nb);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!lad_oe && ldrq_n && !loc_rd && !loc_wr, "R12", {lad_oe, ldrq_n, loc_rd, loc_wr}, 4'b0100);
    rst_n = 1'b1;
    tick(1'b1, 4'hF);

    for (int v = 0; v < NVEC; v++) io_cycle(VEC[v][27:24], VEC[v][23:8], VEC[v][7:0]);

    dma_read(2'b00, 1, -1);
    dma_read(2'b01, 2, -1);
    dma_read(2'b11, 4, -1);
    dma_write(2'b00, 1);
    dma_write(2'b11, 4);

    // R6: back-end stretches the cycle
    p_ready = 1'b0; p_rdata = 8'hA7;
    io_head(4'h0, 16'h0304, 8'h00);
    repeat (8) exp_nib(4'b0110, "R6");
    p_ready = 1'b1;
    exp_nib(4'b0000, "R6");
    exp_nib(4'h7, "R6"); exp_nib(4'hA, "R6");
    exp_nib(4'hF, "R6"); exp_off("R6");

    // R7: timeout on a write
    p_ready = 1'b0;
    io_head(4'h2, 16'h0301, 8'h99);
    repeat (TO) exp_nib(4'b0110, "R7");
    exp_nib(4'b1010, "R7");
    exp_nib(4'hF, "R7"); exp_off("R7");
    p_ready = 1'b1;
    tick(1'b1, 4'hF);

    // R8: error on an I/O read still returns data nibbles
    p_err = 1'b1; p_rdata = 8'h6B;
    io_head(4'h0, 16'h0302, 8'h00);
    repeat (3) exp_nib(4'b0110, "R8");
    exp_nib(4'b1010, "R8");
    exp_nib(4'hB, "R8"); exp_nib(4'h6, "R8");
    exp_nib(4'hF, "R8"); exp_off("R8");
    p_err = 1'b0;

    // R9: error ends DMA early
    dma_read(2'b11, 4, 1);
    dma_read(2'b11, 4, 0);

    // R11: abort during SYNC
    io_head(4'h0, 16'h0302, 8'h00);
    exp_nib(4'b0110, "R11");
    tick(1'b0, 4'hF);
    repeat (4) exp_off("R11");
    // R1: START must be 0000 on the last low clock
    tick(1'b0, 4'h0); tick(1'b0, 4'h5); tick(1'b1, 4'h0);
    tick(1'b1, 4'h0); tick(1'b1, 4'h3); tick(1'b1, 4'h0); tick(1'b1, 4'h0);
    tick(1'b1, 4'hF); tick(1'b1, 4'hF);
    repeat (6) exp_off("R1");
    // R11: fresh START mid-cycle restarts decoding
    tick(1'b0, 4'h0); tick(1'b1, 4'h0); tick(1'b1, 4'h0);
    io_cycle(4'h0, 16'h030A, 8'hE1);

    // R12: reset mid-cycle
    io_head(4'h0, 16'h0303, 8'h00);
    exp_nib(4'b0110, "R12");
    rst_n = 1'b0;
    #1;
    chk(!lad_oe && ldrq_n, "R12", {lad_oe, ldrq_n}, 2'b01);
    tick(1'b0, 4'h0); tick(1'b1, 4'h0);
    for (int i = 0; i < 8; i++) begin
      tick(1'b1, 4'h0);
      chk(!s_oe && ldrq_n && !loc_rd, "R12", {s_oe, ldrq_n}, 2'b01);
    end
    rst_n = 1'b1;
    io_cycle(4'h0, 16'h0308, 8'h4D);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule